// File: doc/BRIEF.md
# DMA channel start/stop manager

This block sits between software and the per-channel logic of a multi-channel transmit DMA engine. Software reaches it over a simple memory-mapped register bus: every channel owns a small window of registers. One register holds the enable that software wants. One reports whether the channel is really running. Two hold pointer values that the channel logic reports back.

The block compares the wanted enable of each channel with its actual running state. For any channel where the two differ, it sends a start or stop request to the channel logic over a valid/acknowledge handshake. Only one request is outstanding at any time, even when software changes many channels at once. The next channel to serve is picked in round-robin order. The running state of a channel changes only when the channel logic acknowledges the request.

The channel logic also writes hardware data-pointer and header-pointer values through two dedicated write ports. Software can read these values back.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After synchronous active-high reset, `chan_active` is all zero, neither request valid is high, and every register of every channel reads as zero.
- R2: At most one request (start or stop) is outstanding at any time. Requests for several channels are issued one after another.
- R3: A raised `start_vld` or `stop_vld` stays high until the matching acknowledge is sampled with it, and the channel index stays constant for that whole time.
- R4: A channel's `chan_active` bit is set on the clock edge where its start request is acknowledged. It is cleared on the edge where its stop request is acknowledged. Otherwise it does not change.
- R5: Writing 1 to the control bit of a stopped channel produces a start request for that channel. Writing 0 to a running channel produces a stop request. Writing 1 to a running channel, or 0 to a stopped one, produces no request.
- R6: When several channels need service, the next one served is the lowest-indexed channel above the last one served, wrapping past the highest index back to 0. After reset, the search begins at channel 0.
- R7: Register map. The channel number sits in address bits [7 +: log2(channels)], so the per-channel stride is 0x80. The offsets are:
  - 0x0: control word. Bit 0 is the wanted enable. Read/write.
  - 0x4: status word. Bit 0 is the running state. Read-only.
  - 0x8: hardware data pointer, zero-extended. Read-only.
  - 0xC: hardware header pointer, zero-extended. Read-only.
  Any other offset inside the window reads zero. Writes to read-only offsets have no effect.
- R8: `bus_ardy` is high in any cycle where `bus_rd` or `bus_wr` is high. Read data appears on `bus_rdata`, with `bus_drdy` high, in the cycle after the read strobe.
- R9: A write to the control word changes the wanted enable only when byte enable bit 0 is set. With bit 0 clear, the write has no effect.
- R10: When `dptr_we` (or `hptr_we`) is high, the value on `dptr_data` (or `hptr_data`) is stored for the channel given by `dptr_chan` (or `hptr_chan`). Other channels keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | BUS_W | Write data |
| bus_be | input | BUS_W/8 | Byte enables for writes |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | BUS_W | Read data |
| bus_ardy | output | 1 | Request accepted |
| bus_drdy | output | 1 | Read data valid |
| start_chan | output | log2(NUM_CH) | Channel index of the start request |
| start_vld | output | 1 | Start request valid |
| start_ack | input | 1 | Start acknowledge |
| stop_chan | output | log2(NUM_CH) | Channel index of the stop request |
| stop_vld | output | 1 | Stop request valid |
| stop_ack | input | 1 | Stop acknowledge |
| chan_active | output | NUM_CH | Running state, one bit per channel |
| dptr_chan | input | log2(NUM_CH) | Channel for the data-pointer write |
| dptr_data | input | DPTR_W | Data-pointer value |
| dptr_we | input | 1 | Data-pointer write enable |
| hptr_chan | input | log2(NUM_CH) | Channel for the header-pointer write |
| hptr_data | input | HPTR_W | Header-pointer value |
| hptr_we | input | 1 | Header-pointer write enable |

## Verification
The bench builds the block with four channels, a 6-bit data pointer, a 5-bit header pointer and a 16-bit address. With these sizes, every pointer value can be written and read back on every channel. Every byte-enable pattern that leaves bit 0 clear is tried. Four channels are also enough to make the round-robin search wrap past the highest index while other requests are still queued, for both starts and stops, and to follow a start with a stop on a different channel.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

   // Word select inside one channel window (address bits [3:2])
   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_STAT = 2'd1,
      REG_DPTR = 2'd2,
      REG_HPTR = 2'd3
   } dcc_reg_e;

   typedef enum logic {
      REQ_START = 1'b0,
      REQ_STOP  = 1'b1
   } dcc_kind_e;

endpackage

// File: rtl/dcc_pick.sv
// Round-robin picker: the first set request strictly after `last`, wrapping.
module dcc_pick #(
   parameter int NCH = 8,
   parameter int CW  = $clog2(NCH)
) (
   input  logic [NCH-1:0] req,
   input  logic [CW-1:0]  last,
   output logic           hit,
   output logic [CW-1:0]  sel
);

   localparam bool_pow2 = (NCH == (1 << CW));

   logic [CW-1:0] cand [NCH];

   generate
      for (genvar k = 0; k < NCH; k++) begin : g_cand
         if (bool_pow2) begin : g_wrap_free
            // the index wraps by truncation
            assign cand[k] = last + CW'(k + 1);
         end else begin : g_wrap_cmp
            logic [CW:0] sum;
            assign sum     = {1'b0, last} + (CW+1)'(k + 1);
            assign cand[k] = (sum >= (CW+1)'(NCH)) ? CW'(sum - (CW+1)'(NCH)) : CW'(sum);
         end
      end
   endgenerate

   always_comb begin
      hit = 1'b0;
      sel = '0;
      // walk from the far end so the nearest candidate wins
      for (int k = NCH - 1; k >= 0; k--) begin
         if (req[cand[k]]) begin
            hit = 1'b1;
            sel = cand[k];
         end
      end
   end

endmodule

// File: rtl/dcc_seq.sv
// Serialising request engine: one start or stop outstanding at a time.
module dcc_seq
   import dcc_pkg::*;
#(
   parameter int NCH = 8,
   parameter int CW  = $clog2(NCH)
) (
   input  logic           clk,
   input  logic           rst,
   input  logic [NCH-1:0] want,
   input  logic           start_ack,
   input  logic           stop_ack,
   output logic [NCH-1:0] active,
   output logic [CW-1:0]  start_chan,
   output logic           start_vld,
   output logic [CW-1:0]  stop_chan,
   output logic           stop_vld
);

   logic [NCH-1:0] need_up;
   logic [NCH-1:0] need_dn;
   logic [NCH-1:0] need;
   logic           hit;
   logic [CW-1:0]  sel;

   logic           busy_q;
   logic [CW-1:0]  cur_q;
   logic [CW-1:0]  last_q;
   dcc_kind_e      kind_q;
   logic [NCH-1:0] active_q;
   logic           done;

   // pending work is the difference between wanted and actual state
   assign need_up = want & ~active_q;
   assign need_dn = ~want & active_q;
   assign need    = need_up | need_dn;

   dcc_pick #(.NCH(NCH), .CW(CW)) u_pick (
      .req  (need),
      .last (last_q),
      .hit  (hit),
      .sel  (sel)
   );

   assign done = busy_q & ((kind_q == REQ_START) ? start_ack : stop_ack);

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q   <= 1'b0;
         cur_q    <= '0;
         last_q   <= CW'(NCH - 1);
         kind_q   <= REQ_START;
         active_q <= '0;
      end else if (!busy_q) begin
         if (hit) begin
            busy_q <= 1'b1;
            cur_q  <= sel;
            kind_q <= need_up[sel] ? REQ_START : REQ_STOP;
         end
      end else if (done) begin
         busy_q          <= 1'b0;
         last_q          <= cur_q;
         active_q[cur_q] <= (kind_q == REQ_START);
      end
   end

   assign active     = active_q;
   assign start_vld  = busy_q & (kind_q == REQ_START);
   assign stop_vld   = busy_q & (kind_q == REQ_STOP);
   assign start_chan = cur_q;
   assign stop_chan  = cur_q;

endmodule

// File: rtl/dcc_regs.sv
// Per-channel register windows, pointer capture and the read path.
module dcc_regs
   import dcc_pkg::*;
#(
   parameter int NCH       = 8,
   parameter int CW        = $clog2(NCH),
   parameter int DW_D      = 14,
   parameter int DW_H      = 9,
   parameter int BUS_W     = 32,
   parameter int ADDR_W    = 32,
   parameter int STRIDE_LG = 7
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [BUS_W-1:0]   wdata,
   input  logic [BUS_W/8-1:0] be,
   input  logic               rd,
   input  logic               wr,
   input  logic [NCH-1:0]     active,
   input  logic [CW-1:0]      dptr_chan,
   input  logic [DW_D-1:0]    dptr_data,
   input  logic               dptr_we,
   input  logic [CW-1:0]      hptr_chan,
   input  logic [DW_H-1:0]    hptr_data,
   input  logic               hptr_we,
   output logic [NCH-1:0]     want,
   output logic [BUS_W-1:0]   rdata,
   output logic               ardy,
   output logic               drdy
);

   localparam int  BE_W = BUS_W / 8;
   localparam bit  POW2 = (NCH == (1 << CW));

   logic [CW-1:0]        a_ch;
   logic [STRIDE_LG-1:0] a_off;
   logic                 off_ok;
   logic                 ch_ok;
   dcc_reg_e             reg_sel;
   logic                 ctrl_wr;

   logic [DW_D-1:0] dptr_all [NCH];
   logic [DW_H-1:0] hptr_all [NCH];

   assign a_ch    = addr[STRIDE_LG +: CW];
   assign a_off   = addr[STRIDE_LG-1:0];
   assign off_ok  = (a_off[STRIDE_LG-1:4] == '0) && (a_off[1:0] == 2'b00);
   assign reg_sel = dcc_reg_e'(a_off[3:2]);

   generate
      if (POW2) begin : g_ch_full
         assign ch_ok = 1'b1;
      end else begin : g_ch_range
         assign ch_ok = ({1'b0, a_ch} < (CW+1)'(NCH));
      end
   endgenerate

   assign ctrl_wr = wr & off_ok & ch_ok & (reg_sel == REG_CTRL) & be[0];

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         logic            want_r;
         logic [DW_D-1:0] dp_r;
         logic [DW_H-1:0] hp_r;

         always_ff @(posedge clk) begin
            if (rst) begin
               want_r <= 1'b0;
               dp_r   <= '0;
               hp_r   <= '0;
            end else begin
               if (ctrl_wr && (a_ch == CW'(c)))
                  want_r <= wdata[0];
               if (dptr_we && (dptr_chan == CW'(c)))
                  dp_r <= dptr_data;
               if (hptr_we && (hptr_chan == CW'(c)))
                  hp_r <= hptr_data;
            end
         end

         assign want[c]     = want_r;
         assign dptr_all[c] = dp_r;
         assign hptr_all[c] = hp_r;
      end
   endgenerate

   logic [BUS_W-1:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      if (off_ok && ch_ok) begin
         case (reg_sel)
            REG_CTRL: rd_mux[0]        = want[a_ch];
            REG_STAT: rd_mux[0]        = active[a_ch];
            REG_DPTR: rd_mux[DW_D-1:0] = dptr_all[a_ch];
            REG_HPTR: rd_mux[DW_H-1:0] = hptr_all[a_ch];
            default:  rd_mux           = '0;
         endcase
      end
   end

   logic [BUS_W-1:0] rdata_q;
   logic             drdy_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         rdata_q <= '0;
         drdy_q  <= 1'b0;
      end else begin
         drdy_q <= rd;
         if (rd)
            rdata_q <= rd_mux;
      end
   end

   assign rdata = rdata_q;
   assign drdy  = drdy_q;
   assign ardy  = rd | wr;

   // address bits above the window, and data bits the control word does not use
   logic unused_bits;
   assign unused_bits = ^{addr[ADDR_W-1:STRIDE_LG+CW], wdata[BUS_W-1:1], be[BE_W-1:1]};

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl #(
   parameter int NUM_CH    = 8,
   parameter int DPTR_W    = 14,
   parameter int HPTR_W    = 9,
   parameter int BUS_W     = 32,
   parameter int ADDR_W    = 32,
   parameter int STRIDE_LG = 7,
   localparam int CW       = $clog2(NUM_CH),
   localparam int BE_W     = BUS_W / 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   input  logic [BE_W-1:0]   bus_be,
   input  logic              bus_rd,
   input  logic              bus_wr,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              bus_ardy,
   output logic              bus_drdy,
   output logic [CW-1:0]     start_chan,
   output logic              start_vld,
   input  logic              start_ack,
   output logic [CW-1:0]     stop_chan,
   output logic              stop_vld,
   input  logic              stop_ack,
   output logic [NUM_CH-1:0] chan_active,
   input  logic [CW-1:0]     dptr_chan,
   input  logic [DPTR_W-1:0] dptr_data,
   input  logic              dptr_we,
   input  logic [CW-1:0]     hptr_chan,
   input  logic [HPTR_W-1:0] hptr_data,
   input  logic              hptr_we
);

   generate
      if (NUM_CH < 2) begin : g_bad_nch
         $error("dma_chan_ctrl: NUM_CH must be at least 2");
      end
      if ((BUS_W % 8) != 0) begin : g_bad_bus
         $error("dma_chan_ctrl: BUS_W must be a whole number of bytes");
      end
      if ((DPTR_W > BUS_W) || (HPTR_W > BUS_W)) begin : g_bad_ptr
         $error("dma_chan_ctrl: pointer widths must fit the bus word");
      end
      if (STRIDE_LG < 5) begin : g_bad_stride
         $error("dma_chan_ctrl: channel window must hold at least 32 bytes");
      end
      if (ADDR_W <= STRIDE_LG + CW) begin : g_bad_addr
         $error("dma_chan_ctrl: ADDR_W too small for the channel windows");
      end
   endgenerate

   logic [NUM_CH-1:0] want;
   logic [NUM_CH-1:0] active;

   dcc_regs #(
      .NCH       (NUM_CH),
      .CW        (CW),
      .DW_D      (DPTR_W),
      .DW_H      (HPTR_W),
      .BUS_W     (BUS_W),
      .ADDR_W    (ADDR_W),
      .STRIDE_LG (STRIDE_LG)
   ) u_regs (
      .clk       (clk),
      .rst       (rst),
      .addr      (bus_addr),
      .wdata     (bus_wdata),
      .be        (bus_be),
      .rd        (bus_rd),
      .wr        (bus_wr),
      .active    (active),
      .dptr_chan (dptr_chan),
      .dptr_data (dptr_data),
      .dptr_we   (dptr_we),
      .hptr_chan (hptr_chan),
      .hptr_data (hptr_data),
      .hptr_we   (hptr_we),
      .want      (want),
      .rdata     (bus_rdata),
      .ardy      (bus_ardy),
      .drdy      (bus_drdy)
   );

   dcc_seq #(
      .NCH (NUM_CH),
      .CW  (CW)
   ) u_seq (
      .clk        (clk),
      .rst        (rst),
      .want       (want),
      .start_ack  (start_ack),
      .stop_ack   (stop_ack),
      .active     (active),
      .start_chan (start_chan),
      .start_vld  (start_vld),
      .stop_chan  (stop_chan),
      .stop_vld   (stop_vld)
   );

   assign chan_active = active;

endmodule

// File: rtl/dcc_chk.sv
module dcc_chk #(
   parameter int NCH = 8,
   parameter int CW  = 3
) (
   input logic           clk,
   input logic           rst,
   input logic           bus_rd,
   input logic           bus_drdy,
   input logic [CW-1:0]  start_chan,
   input logic           start_vld,
   input logic           start_ack,
   input logic [CW-1:0]  stop_chan,
   input logic           stop_vld,
   input logic           stop_ack,
   input logic [NCH-1:0] chan_active
);

   AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (chan_active == '0) && !start_vld && !stop_vld); // R1
   AST_ONE_REQ: assert property (@(posedge clk) disable iff (rst) !(start_vld && stop_vld)); // R2
   AST_START_HOLD: assert property (@(posedge clk) disable iff (rst) (start_vld && !start_ack) |=> start_vld && $stable(start_chan)); // R3
   AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst) (stop_vld && !stop_ack) |=> stop_vld && $stable(stop_chan)); // R3
   AST_START_SETS: assert property (@(posedge clk) disable iff (rst) (start_vld && start_ack) |=> chan_active[$past(start_chan)]); // R4
   AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst) (stop_vld && stop_ack) |=> !chan_active[$past(stop_chan)]); // R4
   AST_ACTIVE_STABLE: assert property (@(posedge clk) disable iff (rst) (!(start_vld && start_ack) && !(stop_vld && stop_ack)) |=> $stable(chan_active)); // R4
   AST_START_ON_IDLE: assert property (@(posedge clk) disable iff (rst) start_vld |-> !chan_active[start_chan]); // R5
   AST_STOP_ON_RUN: assert property (@(posedge clk) disable iff (rst) stop_vld |-> chan_active[stop_chan]); // R5
   AST_READ_DRDY: assert property (@(posedge clk) disable iff (rst) bus_rd |=> bus_drdy); // R8

endmodule

bind dma_chan_ctrl dcc_chk #(.NCH(NUM_CH), .CW(CW)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .bus_rd      (bus_rd),
   .bus_drdy    (bus_drdy),
   .start_chan  (start_chan),
   .start_vld   (start_vld),
   .start_ack   (start_ack),
   .stop_chan   (stop_chan),
   .stop_vld    (stop_vld),
   .stop_ack    (stop_ack),
   .chan_active (chan_active)
);

// File: tb/dma_chan_ctrl_test.sv
module dma_chan_ctrl_test;

   localparam int NCH  = 4;
   localparam int CW   = 2;
   localparam int DW_D = 6;
   localparam int DW_H = 5;
   localparam int BW   = 32;
   localparam int AW   = 16;

   localparam logic [6:0] O_CTRL = 7'h00;
   localparam logic [6:0] O_STAT = 7'h04;
   localparam logic [6:0] O_DPTR = 7'h08;
   localparam logic [6:0] O_HPTR = 7'h0C;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2 clk = ~clk;

   logic [AW-1:0]   bus_addr = '0;
   logic [BW-1:0]   bus_wdata = '0;
   logic [BW/8-1:0] bus_be = '0;
   logic            bus_rd = 1'b0;
   logic            bus_wr = 1'b0;
   logic [BW-1:0]   bus_rdata;
   logic            bus_ardy;
   logic            bus_drdy;
   logic [CW-1:0]   start_chan;
   logic            start_vld;
   logic            start_ack = 1'b0;
   logic [CW-1:0]   stop_chan;
   logic            stop_vld;
   logic            stop_ack = 1'b0;
   logic [NCH-1:0]  chan_active;
   logic [CW-1:0]   dptr_chan = '0;
   logic [DW_D-1:0] dptr_data = '0;
   logic            dptr_we = 1'b0;
   logic [CW-1:0]   hptr_chan = '0;
   logic [DW_H-1:0] hptr_data = '0;
   logic            hptr_we = 1'b0;

   dma_chan_ctrl #(
      .NUM_CH (NCH), .DPTR_W (DW_D), .HPTR_W (DW_H),
      .BUS_W (BW), .ADDR_W (AW), .STRIDE_LG (7)
   ) uut (
      .clk (clk), .rst (rst),
      .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_be (bus_be),
      .bus_rd (bus_rd), .bus_wr (bus_wr), .bus_rdata (bus_rdata),
      .bus_ardy (bus_ardy), .bus_drdy (bus_drdy),
      .start_chan (start_chan), .start_vld (start_vld), .start_ack (start_ack),
      .stop_chan (stop_chan), .stop_vld (stop_vld), .stop_ack (stop_ack),
      .chan_active (chan_active),
      .dptr_chan (dptr_chan), .dptr_data (dptr_data), .dptr_we (dptr_we),
      .hptr_chan (hptr_chan), .hptr_data (hptr_data), .hptr_we (hptr_we)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;
   logic [NCH-1:0] exp_active = '0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] adr(input int ch, input logic [6:0] off);
      return AW'(ch * 128) | AW'(off);
   endfunction

   task automatic bus_write(input int ch, input logic [6:0] off, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      bus_addr  = adr(ch, off);
      bus_wdata = d;
      bus_be    = be;
      bus_wr    = 1'b1;
      #1 check("R8 ardy with write strobe", 32'(bus_ardy), 32'd1);
      @(negedge clk);
      bus_wr = 1'b0;
      bus_be = '0;
   endtask

   task automatic bus_read(input int ch, input logic [6:0] off, output logic [31:0] d);
      @(negedge clk);
      bus_addr = adr(ch, off);
      bus_rd   = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      check("R8 drdy one cycle after read", 32'(bus_drdy), 32'd1);
      d = bus_rdata;
   endtask

   task automatic read_expect(input string tag, input int ch, input logic [6:0] off, input logic [31:0] exp);
      logic [31:0] d;
      bus_read(ch, off, d);
      check(tag, d, exp);
   endtask

   // wait for a request, check its kind and index, and that it holds
   task automatic wait_req(input bit is_stop, input int ch, input string tag);
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (start_vld || stop_vld) break;
      end
      check({tag, " R2 single request"}, 32'(start_vld && stop_vld), 32'd0);
      check({tag, " R5 request kind"}, {30'd0, start_vld, stop_vld}, is_stop ? 32'd1 : 32'd2);
      check({tag, " R6 request channel"}, 32'(is_stop ? stop_chan : start_chan), 32'(ch));
      repeat (2) @(negedge clk);
      check({tag, " R3 request held"}, {30'd0, start_vld, stop_vld}, is_stop ? 32'd1 : 32'd2);
      check({tag, " R3 index stable"}, 32'(is_stop ? stop_chan : start_chan), 32'(ch));
   endtask

   task automatic give_ack(input bit is_stop, input int ch);
      @(negedge clk);
      check("R3 still pending before ack", 32'(is_stop ? stop_vld : start_vld), 32'd1);
      check("R4 not yet changed before ack", 32'(chan_active), 32'(exp_active));
      if (is_stop) stop_ack = 1'b1; else start_ack = 1'b1;
      @(negedge clk);
      start_ack = 1'b0;
      stop_ack  = 1'b0;
      exp_active[ch] = !is_stop;
      check("R4 active after ack", 32'(chan_active), 32'(exp_active));
   endtask

   task automatic expect_none(input string tag);
      bit seen = 1'b0;
      repeat (6) begin
         @(negedge clk);
         if (start_vld || stop_vld) seen = 1'b1;
      end
      check(tag, 32'(seen), 32'd0);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R1: reset state
      check("R1 active after reset", 32'(chan_active), 32'd0);
      check("R1 no request after reset", {30'd0, start_vld, stop_vld}, 32'd0);
      check("R1 drdy idle", 32'(bus_drdy), 32'd0);
      for (int c = 0; c < NCH; c++) begin
         read_expect("R1 ctrl zero", c, O_CTRL, 32'd0);
         read_expect("R1 status zero", c, O_STAT, 32'd0);
         read_expect("R1 dptr zero", c, O_DPTR, 32'd0);
         read_expect("R1 hptr zero", c, O_HPTR, 32'd0);
      end

      // R10: exhaustive pointer sweep on every channel
      for (int c = 0; c < NCH; c++) begin
         for (int v = 0; v < (1 << DW_D); v++) begin
            @(negedge clk);
            dptr_chan = CW'(c); dptr_data = DW_D'(v); dptr_we = 1'b1;
            @(negedge clk);
            dptr_we = 1'b0;
            read_expect("R10 dptr readback", c, O_DPTR, 32'(v));
         end
         for (int v = 0; v < (1 << DW_H); v++) begin
            @(negedge clk);
            hptr_chan = CW'(c); hptr_data = DW_H'(v); hptr_we = 1'b1;
            @(negedge clk);
            hptr_we = 1'b0;
            read_expect("R10 hptr readback", c, O_HPTR, 32'(v));
         end
      end
      @(negedge clk);
      dptr_chan = 2'd1; dptr_data = 6'd5; dptr_we = 1'b1;
      hptr_chan = 2'd2; hptr_data = 5'd9; hptr_we = 1'b1;
      @(negedge clk);
      dptr_we = 1'b0; hptr_we = 1'b0;
      read_expect("R10 dptr target", 1, O_DPTR, 32'd5);
      read_expect("R10 dptr neighbour kept", 0, O_DPTR, 32'd63);
      read_expect("R10 hptr target", 2, O_HPTR, 32'd9);
      read_expect("R10 hptr neighbour kept", 3, O_HPTR, 32'd31);

      // R9: byte-enable patterns with bit 0 clear leave control untouched
      for (int b = 0; b < 16; b += 2) begin
         bus_write(2, O_CTRL, 32'hFFFF_FFFF, 4'(b));
         read_expect("R9 ctrl unchanged without be0", 2, O_CTRL, 32'd0);
      end
      expect_none("R9 no request without be0");

      // R5/R4/R7: start channel 2
      bus_write(2, O_CTRL, 32'd1, 4'b0001);
      wait_req(1'b0, 2, "start ch2");
      give_ack(1'b0, 2);
      read_expect("R7 status shows running", 2, O_STAT, 32'd1);
      read_expect("R7 ctrl shows wanted", 2, O_CTRL, 32'd1);

      // R5: redundant commands produce nothing
      bus_write(2, O_CTRL, 32'd1, 4'b0001);
      expect_none("R5 start on running channel");
      bus_write(1, O_CTRL, 32'd0, 4'b0001);
      expect_none("R5 stop on stopped channel");

      // R7: read-only offsets, unused offsets
      bus_write(2, O_STAT, 32'd0, 4'b1111);
      expect_none("R7 status write gives no request");
      read_expect("R7 status write ignored", 2, O_STAT, 32'd1);
      bus_write(1, O_DPTR, 32'h0000_0000, 4'b1111);
      read_expect("R7 dptr write ignored", 1, O_DPTR, 32'd5);
      read_expect("R7 unused offset reads zero", 2, 7'h10, 32'd0);
      read_expect("R7 unaligned offset reads zero", 2, 7'h01, 32'd0);

      // R6: starts queued behind an in-flight one, wrapping after channel 3
      bus_write(3, O_CTRL, 32'd1, 4'b0001);
      wait_req(1'b0, 3, "start ch3");
      bus_write(1, O_CTRL, 32'd1, 4'b0001);
      bus_write(0, O_CTRL, 32'd1, 4'b0001);
      give_ack(1'b0, 3);
      wait_req(1'b0, 0, "R6 start wraps to ch0");
      give_ack(1'b0, 0);
      wait_req(1'b0, 1, "R6 start next ch1");
      give_ack(1'b0, 1);
      check("R4 all running", 32'(chan_active), 32'hF);

      // R6: stops, last served 2 then 3 then wrap to 0
      bus_write(2, O_CTRL, 32'd0, 4'b0001);
      wait_req(1'b1, 2, "stop ch2");
      bus_write(0, O_CTRL, 32'd0, 4'b0001);
      bus_write(3, O_CTRL, 32'd0, 4'b0001);
      give_ack(1'b1, 2);
      wait_req(1'b1, 3, "R6 stop next ch3");
      give_ack(1'b1, 3);
      wait_req(1'b1, 0, "R6 stop wraps to ch0");
      give_ack(1'b1, 0);
      check("R4 only ch1 running", 32'(chan_active), 32'h2);

      // R2: a start followed by a stop on another channel
      bus_write(0, O_CTRL, 32'd1, 4'b0001);
      wait_req(1'b0, 0, "start ch0");
      bus_write(1, O_CTRL, 32'd0, 4'b0001);
      give_ack(1'b0, 0);
      wait_req(1'b1, 1, "R2 stop after start");
      give_ack(1'b1, 1);
      expect_none("R2 queue drained");
      read_expect("R7 status ch1 stopped", 1, O_STAT, 32'd0);
      read_expect("R7 status ch0 running", 0, O_STAT, 32'd1);

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule